// File: doc/BRIEF.md
# Two-Channel Hardware Break Unit

This block sits beside a processor's memory-access bus and raises a debug break request when an access meets conditions that software has programmed. There are two channels, A and B, and each one works on its own. A channel can test the access address under a bit mask, the data value, the access kind (instruction fetch, read or write) and the access size (byte, halfword or word). Each of these tests can be switched on or off separately.

In sequential mode a break is raised only when a channel-B match follows an earlier channel-A match. Each channel also keeps a sticky hit flag that software clears. The block supplies the base address of the break handler. That address is a dedicated debug base when debug handling is enabled, and the normal vector base otherwise.

Software programs the block through a simple write port. Each write selects one of twelve register slots. A write takes effect for accesses from the following cycle onward.

Top module: `brk_unit`

## Requirements
- R1: A channel's address test passes only when `(acc_addr ^ ref) & ~mask` is zero. Bits set in the mask register are ignored.
- R2: With the data-test bit (control bit 1) set, the channel compares only the data lanes that the access size selects: bits 7:0 for size 00 (byte), bits 15:0 for size 01 (halfword) and all bits for size 10 (word).
- R3: Control bits 3:2 give the kind condition: 00 = any, 01 = fetch, 10 = read, 11 = write. The bus kind input uses the same codes 01, 10 and 11. A nonzero condition passes only on an equal bus kind.
- R4: With the size-test bit (control bit 4) set, the channel matches only when the access size equals control bits 6:5.
- R5: A channel whose enable bit (control bit 0) is clear never matches.
- R6: With sequential mode off, `brk_req` is high for exactly the one cycle after each sampled access that matches either enabled channel. The request is never raised without a sampled access.
- R7: With sequential mode on (global bit 0), an A match arms the sequence. A later access that matches B while armed raises `brk_req` and disarms it. A B match while unarmed raises nothing.
- R8: The armed state is cleared by reset and by any global-register write that changes the sequential-mode bit.
- R9: Each channel's hit flag (`hit_flags[0]` for A, `hit_flags[1]` for B) sets on a match and stays set until a 1 is written to the matching bit of the clear register (slot 9).
- R10: `handler_base` shows the debug base (slot 11) when the debug-enable bit (global bit 1) is set, and the vector base (slot 10) otherwise. It changes one cycle after the register that feeds it.
- R11: A register write takes effect for accesses sampled from the next clock onward. An access in the same cycle as the write uses the old settings.
- R12: After reset all registers are zero, so both channels are disabled, and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_idx | input | 4 | Register slot: 0-3 A address/mask/data/control, 4-7 same for B, 8 global, 9 flag clear, 10 vector base, 11 debug base |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | Access present on the bus this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_data | input | DATA_W | Access data value |
| acc_kind | input | 2 | 01 fetch, 10 read, 11 write |
| acc_size | input | 2 | 00 byte, 01 halfword, 10 word |
| brk_req | output | 1 | Registered break request |
| hit_flags | output | 2 | Sticky per-channel hit flags |
| seq_armed | output | 1 | Sequential mode has seen an A match |
| handler_base | output | ADDR_W | Break handler base address |

## Verification
The bench builds the block with its default widths: a 32-bit address and 32-bit data. At these widths a byte and a halfword access can carry the same low bits as a word while differing in the upper lanes, so the lane selection by size is exercised. The full 32-bit base values are also reachable, and the bench uses them to tell the two handler sources apart. The sequential cases cover a B match before arming, an A match followed by an unrelated access and then B, and a mode change that drops the armed state.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int NCH       = 2;
  localparam int SLOTS_PER = 4;
  localparam int IDX_GLOB  = 8;
  localparam int IDX_CLR   = 9;
  localparam int IDX_VBASE = 10;
  localparam int IDX_DBASE = 11;

  localparam logic [1:0] KIND_ANY = 2'b00;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  typedef struct packed {
    logic [1:0] size;
    logic       size_en;
    logic [1:0] kind;
    logic       data_en;
    logic       en;
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);
endpackage

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [ADDR_W-1:0] a_ref [NCH],
  output logic [ADDR_W-1:0] a_msk [NCH],
  output logic [DATA_W-1:0] d_ref [NCH],
  output chan_ctrl_t        ctrl  [NCH],
  output logic              seq_mode,
  output logic              dbg_en,
  output logic [ADDR_W-1:0] vbase,
  output logic [ADDR_W-1:0] dbase,
  output logic [NCH-1:0]    clr,
  output logic              mode_chg
);
  function automatic logic hit_idx(input logic [IDX_W-1:0] idx, input int slot);
    return idx == IDX_W'(slot);
  endfunction

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    localparam int BASE = ch * SLOTS_PER;
    always_ff @(posedge clk) begin
      if (rst) begin
        a_ref[ch] <= '0;
        a_msk[ch] <= '0;
        d_ref[ch] <= '0;
        ctrl[ch]  <= '0;
      end else if (cfg_we) begin
        if (hit_idx(cfg_idx, BASE + 0)) a_ref[ch] <= cfg_wdata[ADDR_W-1:0];
        if (hit_idx(cfg_idx, BASE + 1)) a_msk[ch] <= cfg_wdata[ADDR_W-1:0];
        if (hit_idx(cfg_idx, BASE + 2)) d_ref[ch] <= cfg_wdata[DATA_W-1:0];
        if (hit_idx(cfg_idx, BASE + 3)) ctrl[ch]  <= chan_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_mode <= 1'b0;
      dbg_en   <= 1'b0;
      vbase    <= '0;
      dbase    <= '0;
    end else if (cfg_we) begin
      if (hit_idx(cfg_idx, IDX_GLOB)) begin
        seq_mode <= cfg_wdata[0];
        dbg_en   <= cfg_wdata[1];
      end
      if (hit_idx(cfg_idx, IDX_VBASE)) vbase <= cfg_wdata[ADDR_W-1:0];
      if (hit_idx(cfg_idx, IDX_DBASE)) dbase <= cfg_wdata[ADDR_W-1:0];
    end
  end

  always_comb begin
    mode_chg = cfg_we && hit_idx(cfg_idx, IDX_GLOB) && (cfg_wdata[0] != seq_mode);
    clr      = (cfg_we && hit_idx(cfg_idx, IDX_CLR)) ? cfg_wdata[NCH-1:0] : '0;
  end
endmodule

// File: rtl/brk_chan_match.sv
module brk_chan_match
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  input  logic [ADDR_W-1:0] a_ref,
  input  logic [ADDR_W-1:0] a_msk,
  input  logic [DATA_W-1:0] d_ref,
  input  chan_ctrl_t        ctrl,
  output logic              hit
);
  logic [DATA_W-1:0] lane;
  logic addr_ok, data_ok, kind_ok, size_ok;

  always_comb begin
    case (acc_size)
      SZ_BYTE: lane = DATA_W'(8'hFF);
      SZ_HALF: lane = DATA_W'(16'hFFFF);
      default: lane = '1;
    endcase
    addr_ok = ((acc_addr ^ a_ref) & ~a_msk) == '0;
    data_ok = !ctrl.data_en || (((acc_data ^ d_ref) & lane) == '0);
    kind_ok = (ctrl.kind == KIND_ANY) || (ctrl.kind == acc_kind);
    size_ok = !ctrl.size_en || (ctrl.size == acc_size);
    hit     = acc_valid && ctrl.en && addr_ok && data_ok && kind_ok && size_ok;
  end
endmodule

// File: rtl/brk_seq.sv
module brk_seq
  import brk_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           acc_valid,
  input  logic [NCH-1:0] hit,
  input  logic           seq_mode,
  input  logic           mode_chg,
  input  logic [NCH-1:0] clr,
  output logic           brk_req,
  output logic [NCH-1:0] hit_flags,
  output logic           armed
);
  logic fire;

  always_comb begin
    if (seq_mode) fire = armed && hit[1];
    else          fire = |hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      brk_req   <= 1'b0;
      hit_flags <= '0;
      armed     <= 1'b0;
    end else begin
      brk_req   <= fire;
      hit_flags <= (hit_flags & ~clr) | hit;
      if (mode_chg || !seq_mode) armed <= 1'b0;
      else if (fire)             armed <= 1'b0;
      else if (hit[0])           armed <= 1'b1;
    end
  end

  AST_REQ_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(acc_valid)); // R6
  AST_FLAG_A_STICKY: assert property (@(posedge clk) disable iff (rst)
    (hit_flags[0] && !clr[0]) |=> hit_flags[0]); // R9
  AST_FLAG_B_STICKY: assert property (@(posedge clk) disable iff (rst)
    (hit_flags[1] && !clr[1]) |=> hit_flags[1]); // R9
  AST_SEQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    (brk_req && $past(seq_mode)) |-> $past(armed)); // R7
  AST_MODE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    mode_chg |=> !armed); // R8
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_data,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        acc_size,
  output logic              brk_req,
  output logic [1:0]        hit_flags,
  output logic              seq_armed,
  output logic [ADDR_W-1:0] handler_base
);
  logic [ADDR_W-1:0] a_ref [NCH];
  logic [ADDR_W-1:0] a_msk [NCH];
  logic [DATA_W-1:0] d_ref [NCH];
  chan_ctrl_t        ctrl  [NCH];
  logic              seq_mode, dbg_en, mode_chg;
  logic [ADDR_W-1:0] vbase, dbase;
  logic [NCH-1:0]    clr, hit;

  brk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(32), .IDX_W(4)) regs_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .a_ref(a_ref), .a_msk(a_msk), .d_ref(d_ref), .ctrl(ctrl),
    .seq_mode(seq_mode), .dbg_en(dbg_en), .vbase(vbase), .dbase(dbase),
    .clr(clr), .mode_chg(mode_chg)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_match
    brk_chan_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) match_i (
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
      .acc_kind(acc_kind), .acc_size(acc_size),
      .a_ref(a_ref[ch]), .a_msk(a_msk[ch]), .d_ref(d_ref[ch]), .ctrl(ctrl[ch]),
      .hit(hit[ch])
    );
  end

  brk_seq seq_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .hit(hit),
    .seq_mode(seq_mode), .mode_chg(mode_chg), .clr(clr),
    .brk_req(brk_req), .hit_flags(hit_flags), .armed(seq_armed)
  );

  always_ff @(posedge clk) begin
    if (rst) handler_base <= '0;
    else     handler_base <= dbg_en ? dbase : vbase;
  end
endmodule

// File: tb/brk_unit_tb_top.sv
`timescale 1ns/1ps
module brk_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [31:0] acc_data = '0;
  logic [1:0]  acc_kind = 2'b10;
  logic [1:0]  acc_size = 2'b10;
  logic        brk_req;
  logic [1:0]  hit_flags;
  logic        seq_armed;
  logic [31:0] handler_base;

  int checks = 0;
  int fails  = 0;
  bit    exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  brk_unit dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_data(acc_data),
    .acc_kind(acc_kind), .acc_size(acc_size), .brk_req(brk_req),
    .hit_flags(hit_flags), .seq_armed(seq_armed), .handler_base(handler_base)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one bus cycle: optional write and optional access, then back to idle
  task automatic step(input logic we, input logic [3:0] idx, input logic [31:0] wd,
                      input logic v, input logic [31:0] a, input logic [31:0] d,
                      input logic [1:0] k, input logic [1:0] s,
                      input bit exp, input string tag);
    @(negedge clk);
    cfg_we = we; cfg_idx = idx; cfg_wdata = wd;
    acc_valid = v; acc_addr = a; acc_data = d; acc_kind = k; acc_size = s;
    if (v) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0; acc_valid = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] wd);
    step(1'b1, idx, wd, 1'b0, '0, '0, 2'b10, 2'b10, 1'b0, "");
  endtask

  task automatic acc(input logic [31:0] a, input logic [31:0] d, input logic [1:0] k,
                     input logic [1:0] s, input bit exp, input string tag);
    step(1'b0, '0, '0, 1'b1, a, d, k, s, exp, tag);
  endtask

  // monitor: score each sampled access against the queue
  initial begin
    forever begin
      bit v;
      @(posedge clk);
      v = acc_valid && !rst;
      @(negedge clk);
      if (v) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6: actual access with empty scoreboard expected none");
        end else begin
          bit e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({31'd0, brk_req}, {31'd0, e}, t);
        end
      end else if (brk_req) begin
        checks++; fails++;
        $display("FAIL R6: actual brk_req 1 expected 0 with no access");
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk({31'd0, brk_req}, 0, "R12 brk_req");
    chk({30'd0, hit_flags}, 0, "R12 flags");
    chk({31'd0, seq_armed}, 0, "R12 armed");
    chk(handler_base, 0, "R12 handler");
    acc(32'h1000, 0, 2'b10, 2'b10, 1'b0, "R12 disabled after reset");

    wr(0, 32'h1000); wr(1, 32'hF); wr(3, 32'h01);
    acc(32'h1004, 0, 2'b10, 2'b10, 1'b1, "R1 masked bits ignored");
    chk({30'd0, hit_flags}, 1, "R9 flag A set");
    acc(32'h1010, 0, 2'b10, 2'b10, 1'b0, "R1 unmasked bit differs");
    chk({30'd0, hit_flags}, 1, "R9 flag A held");
    wr(9, 32'h1);
    chk({30'd0, hit_flags}, 0, "R9 flag A cleared");

    wr(3, 32'h0D);
    acc(32'h1000, 0, 2'b10, 2'b10, 1'b0, "R3 read vs write condition");
    acc(32'h1000, 0, 2'b11, 2'b10, 1'b1, "R3 write matches");
    wr(3, 32'h05);
    acc(32'h1000, 0, 2'b01, 2'b10, 1'b1, "R3 fetch matches");
    acc(32'h1000, 0, 2'b11, 2'b10, 1'b0, "R3 write vs fetch condition");

    wr(3, 32'h31);
    acc(32'h1000, 0, 2'b10, 2'b00, 1'b0, "R4 byte vs half condition");
    acc(32'h1000, 0, 2'b10, 2'b01, 1'b1, "R4 half matches");

    wr(2, 32'hAB); wr(3, 32'h03);
    acc(32'h1000, 32'hFFFF_FFAB, 2'b10, 2'b00, 1'b1, "R2 byte lane only");
    acc(32'h1000, 32'hFFFF_FFAB, 2'b10, 2'b10, 1'b0, "R2 word upper lanes differ");
    acc(32'h1000, 32'h0000_00AB, 2'b10, 2'b10, 1'b1, "R2 word equal");
    acc(32'h1000, 32'hFFFF_12AB, 2'b10, 2'b01, 1'b0, "R2 half lane differs");

    wr(3, 32'h00);
    acc(32'h1000, 0, 2'b10, 2'b10, 1'b0, "R5 disabled channel");

    step(1'b1, 4'd3, 32'h01, 1'b1, 32'h1000, 0, 2'b10, 2'b10, 1'b0, "R11 same-cycle write unseen");
    acc(32'h1000, 0, 2'b10, 2'b10, 1'b1, "R11 write seen next cycle");

    wr(4, 32'h2000); wr(5, 32'h0); wr(7, 32'h01); wr(9, 32'h3);
    chk({30'd0, hit_flags}, 0, "R9 both cleared");
    acc(32'h2000, 0, 2'b10, 2'b10, 1'b1, "R6 channel B break");
    chk({30'd0, hit_flags}, 2, "R9 flag B set");
    acc(32'h1000, 0, 2'b10, 2'b10, 1'b1, "R6 channel A break");

    wr(8, 32'h1);
    acc(32'h2000, 0, 2'b10, 2'b10, 1'b0, "R7 B before arming");
    chk({31'd0, seq_armed}, 0, "R7 not armed by B");
    acc(32'h1000, 0, 2'b10, 2'b10, 1'b0, "R7 A only arms");
    chk({31'd0, seq_armed}, 1, "R7 armed by A");
    acc(32'h3000, 0, 2'b10, 2'b10, 1'b0, "R7 unrelated access");
    acc(32'h2000, 0, 2'b10, 2'b10, 1'b1, "R7 B after A fires");
    chk({31'd0, seq_armed}, 0, "R7 disarmed after fire");

    acc(32'h1000, 0, 2'b10, 2'b10, 1'b0, "R7 rearm");
    chk({31'd0, seq_armed}, 1, "R8 armed before mode change");
    wr(8, 32'h0);
    chk({31'd0, seq_armed}, 0, "R8 mode change disarms");
    acc(32'h2000, 0, 2'b10, 2'b10, 1'b1, "R6 non-sequential again");

    wr(10, 32'h8000_0000); wr(11, 32'h9000_0000);
    @(posedge clk); @(negedge clk);
    chk(handler_base, 32'h8000_0000, "R10 vector base");
    wr(8, 32'h2);
    @(posedge clk); @(negedge clk);
    chk(handler_base, 32'h9000_0000, "R10 debug base");

    repeat (3) @(negedge clk);
    chk(exp_q.size(), 0, "R6 scoreboard drained");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule